// File: doc/BRIEF.md
# Partial-Write Read-Modify-Write Merger with SECDED Scrub

This block sits between a posted write path and an ECC-protected memory whose words hold 64 data bits and 8 check bits. A write that covers the whole 64-bit word (all eight byte enables set) is encoded and written straight away. A narrower write needs the rest of the word, so the block reads the stored word at the same address and checks and corrects it. It then merges the new bytes in under the byte enables, recomputes the check bits and writes the full 72-bit word back.

A correctable error in the stored word is repaired during the merge, so a narrow write also scrubs the word. An uncorrectable error cannot be repaired. The merged word is still written, but its check bits are deliberately spoiled so that the word keeps decoding as uncorrectable. When reporting is enabled, every detected error pulses an interrupt and records the word address, the syndrome and the error class. The initiator has already been released by then, because the request is acknowledged the moment it is accepted. Only one request is in flight at a time.

Top module: `pw_rmw_merger`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the block is idle and stays low from acceptance until the write-back cycle has finished.
- R2: A request with `req_be` = 8'hFF issues no memory read and writes the 72-bit word {check bits of `req_data`, `req_data`} to `req_addr`.
- R3: Any other request issues exactly one single-cycle read of `req_addr` and then one write to the same address. In that write, data byte k (bits 8k+7..8k) comes from `req_data` when `req_be[k]` is 1 and from the corrected stored word otherwise.
- R4: Memory words carry data in bits 63:0 and check bits in bits 71:64. Data bit i occupies Hamming position p(i), where p(i) is the i-th integer, counting up from 3, that is not a power of two. Check bit k (k < 7) is the XOR of the data bits whose position has bit k set. Check bit 7 is the XOR of all 64 data bits and check bits 6:0.
- R5: A single flipped bit in the stored word, whether data or check, is corrected before the merge, so the written word carries no error.
- R6: When the stored word holds an uncorrectable error, the merge uses the stored data uncorrected. The written check bits are the R4 check bits of the merged data XOR 8'h03, so the written word decodes as uncorrectable.
- R7: With `ecc_report_en` high, each detected error gives a one-cycle `err_irq` pulse and loads `err_log_addr`, `err_log_multi` (1 = uncorrectable) and `err_log_syndrome`. The syndrome is {parity of all 72 stored bits, 7-bit Hamming position of the failing bit}. A flipped check bit k < 7 gives position 2^k, and a flipped check bit 7 gives {1, 0}.
- R8: With `ecc_report_en` low, errors raise no `err_irq` and leave the log outputs unchanged, while correction still takes place.
- R9: After synchronous reset, `req_ready` is 1, `mem_rd_en`, `mem_wr_en` and `err_irq` are 0, and the log outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_report_en | input | 1 | Enables error interrupt and logging |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request will be accepted |
| req_addr | input | ADDR_W | Word address of the write |
| req_data | input | 64 | Write data |
| req_be | input | 8 | Byte enables, one per data byte |
| mem_rd_en | output | 1 | Single-cycle memory read strobe |
| mem_wr_en | output | 1 | Single-cycle memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 72 | Word to store: {check, data} |
| mem_rdata | input | 72 | Word returned by the memory |
| mem_rvalid | input | 1 | `mem_rdata` is valid this cycle |
| err_irq | output | 1 | One-cycle error interrupt pulse |
| err_log_addr | output | ADDR_W | Address of the last reported error |
| err_log_syndrome | output | 8 | Syndrome of the last reported error |
| err_log_multi | output | 1 | Last reported error was uncorrectable |

## Verification
The hardest case to reach from the ports is a stored word that already holds a fault when a narrow write arrives. Normal traffic through this block always stores clean or deliberately spoiled words. The memory model in the bench is therefore seeded directly with words that have every single bit position flipped in turn, and with every adjacent pair of bits flipped. After each seeded word, a narrow write is issued and the stored result, interrupt count and log are compared with values computed from the code definition. A full-width write over a damaged word, and a run with reporting switched off, cover the bypass and gating paths.

// File: rtl/pw_rmw_pkg.sv
package pw_rmw_pkg;

    localparam int DW  = 64;
    localparam int CW  = 8;
    localparam int NB  = DW / 8;
    localparam int PW  = 7;
    localparam int WW  = DW + CW;

    localparam logic [CW-1:0] POISON_MASK = 8'h03;
    localparam logic [PW-1:0] LAST_POS    = 7'd71;

    typedef logic [DW-1:0] data_t;
    typedef logic [CW-1:0] chk_t;
    typedef logic [NB-1:0] be_t;

    typedef struct packed {
        chk_t  chk;
        data_t data;
    } cword_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK,
        ST_MERGE,
        ST_WRITE
    } state_t;

    typedef enum logic [1:0] {
        ERR_NONE,
        ERR_SINGLE,
        ERR_MULTI
    } err_kind_t;

    typedef struct packed {
        err_kind_t kind;
        chk_t      syn;
        data_t     fixed;
    } dec_t;

    typedef logic [DW-1:0][PW-1:0] posmap_t;

    // Hamming position of every data bit: skip the powers of two.
    function automatic posmap_t build_pos_map();
        posmap_t m;
        int      n;
        m = '0;
        n = 0;
        for (int p = 1; p < 128; p++) begin
            if (n < DW && (p & (p - 1)) != 0) begin
                m[n] = PW'(p);
                n++;
            end
        end
        return m;
    endfunction

    localparam posmap_t POS_MAP = build_pos_map();

    function automatic chk_t ecc_encode(data_t d);
        logic [PW-1:0] h;
        h = '0;
        for (int i = 0; i < DW; i++) begin
            if (d[i]) h = h ^ POS_MAP[i];
        end
        return {(^d) ^ (^h), h};
    endfunction

    function automatic chk_t ecc_syndrome(cword_t w);
        logic [PW-1:0] h;
        h = w.chk[PW-1:0];
        for (int i = 0; i < DW; i++) begin
            if (w.data[i]) h = h ^ POS_MAP[i];
        end
        return {^w, h};
    endfunction

    function automatic err_kind_t ecc_classify(chk_t syn);
        if (syn == '0)                                 return ERR_NONE;
        else if (syn[CW-1] && syn[PW-1:0] <= LAST_POS) return ERR_SINGLE;
        else                                           return ERR_MULTI;
    endfunction

endpackage

// File: rtl/pw_ecc_encoder.sv
module pw_ecc_encoder
    import pw_rmw_pkg::*;
(
    input  data_t data_in,
    input  logic  poison,
    output chk_t  chk_out
);

    always_comb begin
        chk_out = ecc_encode(data_in);
        if (poison) chk_out = chk_out ^ POISON_MASK;
    end

endmodule

// File: rtl/pw_ecc_decoder.sv
module pw_ecc_decoder
    import pw_rmw_pkg::*;
(
    input  cword_t word_in,
    output dec_t   result
);

    chk_t      syn;
    err_kind_t kind;

    always_comb begin
        syn  = ecc_syndrome(word_in);
        kind = ecc_classify(syn);
    end

    // Only a single error in a data position flips a data bit.
    for (genvar i = 0; i < DW; i++) begin : g_fix
        assign result.fixed[i] = word_in.data[i]
            ^ ((kind == ERR_SINGLE) && (syn[PW-1:0] == POS_MAP[i]));
    end

    assign result.syn  = syn;
    assign result.kind = kind;

endmodule

// File: rtl/pw_byte_merge.sv
module pw_byte_merge
    import pw_rmw_pkg::*;
(
    input  data_t old_word,
    input  data_t new_word,
    input  be_t   be,
    output data_t merged
);

    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign merged[8*k +: 8] = be[k] ? new_word[8*k +: 8] : old_word[8*k +: 8];
    end

endmodule

// File: rtl/pw_rmw_ctrl.sv
module pw_rmw_ctrl
    import pw_rmw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              report_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  data_t             req_data,
    input  be_t               req_be,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  cword_t            mem_rdata,
    input  logic              mem_rvalid,
    output cword_t            old_q,
    input  dec_t              dec,
    output data_t             fixed_q,
    output data_t             new_q,
    output be_t               be_q,
    input  data_t             merged,
    output data_t             word_q,
    output logic              poison_q,
    output logic              err_irq,
    output logic [ADDR_W-1:0] err_log_addr,
    output chk_t              err_log_syndrome,
    output logic              err_log_multi
);

    state_t            state;
    logic              rd_sent;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state            <= ST_IDLE;
            rd_sent          <= 1'b0;
            addr_q           <= '0;
            new_q            <= '0;
            be_q             <= '0;
            old_q            <= '0;
            fixed_q          <= '0;
            word_q           <= '0;
            poison_q         <= 1'b0;
            err_irq          <= 1'b0;
            err_log_addr     <= '0;
            err_log_syndrome <= '0;
            err_log_multi    <= 1'b0;
        end else begin
            err_irq <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        new_q  <= req_data;
                        be_q   <= req_be;
                        if (&req_be) begin
                            word_q   <= req_data;
                            poison_q <= 1'b0;
                            state    <= ST_WRITE;
                        end else begin
                            rd_sent <= 1'b0;
                            state   <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    rd_sent <= 1'b1;
                    if (rd_sent && mem_rvalid) begin
                        old_q <= mem_rdata;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    fixed_q  <= dec.fixed;
                    poison_q <= (dec.kind == ERR_MULTI);
                    if (dec.kind != ERR_NONE && report_en) begin
                        err_irq          <= 1'b1;
                        err_log_addr     <= addr_q;
                        err_log_syndrome <= dec.syn;
                        err_log_multi    <= (dec.kind == ERR_MULTI);
                    end
                    state <= ST_MERGE;
                end
                ST_MERGE: begin
                    word_q <= merged;
                    state  <= ST_WRITE;
                end
                ST_WRITE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign mem_rd_en = (state == ST_READ) && !rd_sent;
    assign mem_wr_en = (state == ST_WRITE);
    assign mem_addr  = addr_q;

    // R2
    full_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && (&req_be)) |=> (!mem_rd_en && mem_wr_en));

    // R3
    narrow_reads_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && !(&req_be)) |=> mem_rd_en);

endmodule

// File: rtl/pw_rmw_merger.sv
module pw_rmw_merger
    import pw_rmw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ecc_report_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_data,
    input  logic [7:0]        req_be,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [71:0]       mem_wdata,
    input  logic [71:0]       mem_rdata,
    input  logic              mem_rvalid,
    output logic              err_irq,
    output logic [ADDR_W-1:0] err_log_addr,
    output logic [7:0]        err_log_syndrome,
    output logic              err_log_multi
);

    cword_t old_q;
    dec_t   dec;
    data_t  fixed_q;
    data_t  new_q;
    be_t    be_q;
    data_t  merged;
    data_t  word_q;
    logic   poison_q;
    chk_t   wchk;

    pw_rmw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk              (clk),
        .rst              (rst),
        .report_en        (ecc_report_en),
        .req_valid        (req_valid),
        .req_ready        (req_ready),
        .req_addr         (req_addr),
        .req_data         (req_data),
        .req_be           (req_be),
        .mem_rd_en        (mem_rd_en),
        .mem_wr_en        (mem_wr_en),
        .mem_addr         (mem_addr),
        .mem_rdata        (cword_t'(mem_rdata)),
        .mem_rvalid       (mem_rvalid),
        .old_q            (old_q),
        .dec              (dec),
        .fixed_q          (fixed_q),
        .new_q            (new_q),
        .be_q             (be_q),
        .merged           (merged),
        .word_q           (word_q),
        .poison_q         (poison_q),
        .err_irq          (err_irq),
        .err_log_addr     (err_log_addr),
        .err_log_syndrome (err_log_syndrome),
        .err_log_multi    (err_log_multi)
    );

    pw_ecc_decoder u_dec (
        .word_in (old_q),
        .result  (dec)
    );

    pw_byte_merge u_merge (
        .old_word (fixed_q),
        .new_word (new_q),
        .be       (be_q),
        .merged   (merged)
    );

    pw_ecc_encoder u_enc (
        .data_in (word_q),
        .poison  (poison_q),
        .chk_out (wchk)
    );

    assign mem_wdata = {wchk, word_q};

    // R1
    accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    write_frees_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> req_ready);

    // R3
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R5
    clean_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && !poison_q) |-> (ecc_syndrome(cword_t'(mem_wdata)) == '0));

    // R6
    poison_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && poison_q) |-> (ecc_classify(ecc_syndrome(cword_t'(mem_wdata))) == ERR_MULTI));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> $past(ecc_report_en));

endmodule

// File: tb/pw_rmw_merger_test.sv
module pw_rmw_merger_test;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ecc_report_en = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_data = '0;
    logic [7:0]    req_be = '0;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [71:0]   mem_wdata;
    logic [71:0]   mem_rdata = '0;
    logic          mem_rvalid = 1'b0;
    logic          err_irq;
    logic [AW-1:0] err_log_addr;
    logic [7:0]    err_log_syndrome;
    logic          err_log_multi;

    int checks = 0;
    int failures = 0;
    int rd_count = 0;
    int irq_count = 0;
    int pos_tab [64];
    logic [71:0] mem [16];

    always #2.5 clk = ~clk;

    pw_rmw_merger #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .ecc_report_en(ecc_report_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_be(req_be),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .err_irq(err_irq), .err_log_addr(err_log_addr),
        .err_log_syndrome(err_log_syndrome), .err_log_multi(err_log_multi)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_rd_en) begin
            mem_rdata  <= mem[mem_addr];
            mem_rvalid <= 1'b1;
            rd_count++;
        end
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (err_irq) irq_count++;
    end

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bcheck(input logic [63:0] d);
        logic [7:0] c;
        c = '0;
        for (int k = 0; k < 7; k++)
            for (int i = 0; i < 64; i++)
                if (((pos_tab[i] >> k) & 1) == 1) c[k] = c[k] ^ d[i];
        c[7] = (^d) ^ (^c[6:0]);
        return c;
    endfunction

    function automatic logic [7:0] bsyn(input logic [71:0] w);
        logic [7:0] c;
        c = bcheck(w[63:0]);
        return {^w, w[70:64] ^ c[6:0]};
    endfunction

    function automatic logic [63:0] bmerge(input logic [63:0] o, input logic [63:0] n, input logic [7:0] be);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = be[k] ? n[8*k +: 8] : o[8*k +: 8];
        return r;
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 busy after accept", {71'd0, req_ready}, 72'd0);
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        n = 0;
        for (int p = 1; p < 128 && n < 64; p++)
            if ((p & (p - 1)) != 0) begin pos_tab[n] = p; n++; end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 ready", {71'd0, req_ready}, 72'd1);
        chk("R9 rd_en", {71'd0, mem_rd_en}, 72'd0);
        chk("R9 wr_en", {71'd0, mem_wr_en}, 72'd0);
        chk("R9 irq", {71'd0, err_irq}, 72'd0);
        chk("R9 log", {63'd0, err_log_multi, err_log_syndrome}, 72'd0);

        // R2 R3 R4: sweep every byte-enable pattern over clean words
        for (int b = 0; b < 256; b++) begin
            logic [63:0] od, nd, ex;
            logic [AW-1:0] a;
            int rd0, irq0;
            a  = AW'(b);
            od = {32'(b) * 32'h9E3779B1, 32'(~b) * 32'h85EBCA6B};
            nd = {od[20:0], od[63:21]} ^ 64'hF0F0_3C3C_A5A5_0FF0;
            mem[a] = {bcheck(od), od};
            rd0 = rd_count; irq0 = irq_count;
            do_write(a, nd, 8'(b));
            ex = bmerge(od, nd, 8'(b));
            chk("R3 R4 merged word", mem[a], {bcheck(ex), ex});
            if (b == 255) chk("R2 no read on full write", 72'(rd_count - rd0), 72'd0);
            else          chk("R3 one read on narrow write", 72'(rd_count - rd0), 72'd1);
            chk("R7 no irq on clean word", 72'(irq_count - irq0), 72'd0);
        end

        // R5 R7: every single-bit fault
        for (int j = 0; j < 72; j++) begin
            logic [63:0] od, nd, ex;
            logic [71:0] w;
            logic [7:0] es;
            logic [AW-1:0] a;
            int irq0;
            a  = AW'(j);
            od = 64'h0123_4567_89AB_CDEF ^ (64'(j) * 64'h0101_0101_0101_0101);
            nd = ~od;
            w  = {bcheck(od), od};
            w[j] = ~w[j];
            mem[a] = w;
            irq0 = irq_count;
            do_write(a, nd, 8'h5A);
            ex = bmerge(od, nd, 8'h5A);
            chk("R5 corrected merge", mem[a], {bcheck(ex), ex});
            if (j < 64)       es = {1'b1, 7'(pos_tab[j])};
            else if (j < 71)  es = {1'b1, 7'(1 << (j - 64))};
            else              es = 8'h80;
            chk("R7 irq pulse single", 72'(irq_count - irq0), 72'd1);
            chk("R7 syndrome single", {64'd0, err_log_syndrome}, {64'd0, es});
            chk("R7 addr/class single", {67'd0, err_log_addr, err_log_multi}, {67'd0, a, 1'b0});
        end

        // R6 R7: adjacent double-bit faults
        for (int j = 0; j < 71; j++) begin
            logic [63:0] od, nd, ex;
            logic [71:0] w;
            logic [7:0] ws;
            logic [AW-1:0] a;
            int irq0;
            a  = AW'(j + 3);
            od = 64'hDEAD_BEEF_0BAD_F00D + 64'(j * 977);
            nd = {od[31:0], od[63:32]};
            w  = {bcheck(od), od};
            w[j] = ~w[j];
            w[j+1] = ~w[j+1];
            mem[a] = w;
            irq0 = irq_count;
            do_write(a, nd, 8'h0F);
            ex = bmerge(w[63:0], nd, 8'h0F);
            chk("R6 poisoned word", mem[a], {bcheck(ex) ^ 8'h03, ex});
            ws = bsyn(mem[a]);
            chk("R6 stays uncorrectable", {70'd0, ws[7], ws[6:0] != 7'd0}, {70'd0, 1'b0, 1'b1});
            chk("R7 irq pulse multi", 72'(irq_count - irq0), 72'd1);
            chk("R7 log multi", {63'd0, err_log_multi, err_log_syndrome}, {63'd0, 1'b1, bsyn(w)});
        end

        // R8: reporting disabled, correction still happens
        begin
            logic [63:0] od, nd, ex;
            logic [71:0] w;
            logic [7:0] s0;
            logic [AW-1:0] a0;
            int irq0;
            ecc_report_en = 1'b0;
            od = 64'h1357_9BDF_2468_ACE0;
            nd = 64'h0;
            w  = {bcheck(od), od};
            w[10] = ~w[10];
            mem[5] = w;
            irq0 = irq_count; s0 = err_log_syndrome; a0 = err_log_addr;
            do_write(4'd5, nd, 8'h80);
            ex = bmerge(od, nd, 8'h80);
            chk("R8 still corrected", mem[5], {bcheck(ex), ex});
            chk("R8 no irq", 72'(irq_count - irq0), 72'd0);
            chk("R8 log held", {60'd0, a0, s0}, {60'd0, err_log_addr, err_log_syndrome});
            ecc_report_en = 1'b1;
        end

        // R2: full write over a damaged word
        begin
            logic [71:0] w;
            int rd0, irq0;
            w = 72'h55_AAAA_5555_AAAA_5555;
            mem[9] = w ^ 72'h3;
            rd0 = rd_count; irq0 = irq_count;
            do_write(4'd9, 64'hCAFE_F00D_1234_5678, 8'hFF);
            chk("R2 full write stored", mem[9], {bcheck(64'hCAFE_F00D_1234_5678), 64'hCAFE_F00D_1234_5678});
            chk("R2 full write no read", 72'(rd_count - rd0), 72'd0);
            chk("R2 full write no irq", 72'(irq_count - irq0), 72'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule